// File: doc/BRIEF.md
# Framebuffer Scan-Out Address Generator

This block streams a fixed true-colour frame out of memory toward a display. Software loads a frame base address and a control word through a two-entry register port. The block walks the visible raster, issues one word read per visible pixel, and splits each returned 32-bit word into 8-bit red, green and blue channels. The channels come with a data-enable and active-low horizontal and vertical sync from free-running timing counters.

Memory is laid out with a fixed stride of 1024 words per line, and only the leading visible words of each line are read. The base is kept only at 2 MiB granularity: the low 21 bits of every byte address come from the scan position. A control bit turns the scan around completely, so the image appears rotated by 180 degrees. Another control bit gates fetching and blacks out the colour outputs. The timing and read-latency figures are parameters. Defaults give 640x480 with a 2-cycle read port.

Top module: `fb_scanout`

## Requirements
- R1: After reset both registers read as zero. The block issues no reads, drives black, holds de_o low and both syncs high, and issues no read and shows black for the whole first frame.
- R2: With rotation off, the word address is {base[31:21], line[8:0], column[9:0]}. Within a line the column counts up by one per pixel from 0, and lines are taken in order 0 upward.
- R3: Lines are 1024 words apart. Column values at or beyond the visible width (640) are never read.
- R4: With control bit 1 set, the scan starts at column 639 of line 479 and counts down through columns and lines.
- R5: For each data-enabled pixel, red_o = word[23:16], green_o = word[15:8] and blue_o = word[7:0] of that pixel's word. Bits 31:24 have no effect.
- R6: With control bit 0 clear, no read is issued and red_o/green_o/blue_o are zero. Data-enable and syncs keep running.
- R7: Register writes go to live registers that are copied into the scan settings only when vertical blanking starts. A write during a visible frame does not change that frame.
- R8: Writing base-register bits 20:0 has no effect on any read address.
- R9: The sync timing is as follows. hsync_n_o is low for H_SYNC clocks out of every H_TOT clocks, and vsync_n_o falls once every H_TOT*V_TOT clocks. de_o is high for exactly H_VIS*V_VIS clocks per frame and never while either sync is low. The colour shown during a de_o cycle is from the word fetched for that pixel (RD_LAT cycles after the address).
- R10: Writing 0 to control blanks the next frame, and writing the enable value again restores the picture on the frame after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects base register, 1 selects control (bit 0 enable, bit 1 rotate) |
| reg_wdata | input | 32 | Register write data |
| mem_rd_o | output | 1 | Read request |
| mem_addr_o | output | 30 | Word read address |
| mem_rdata_i | input | 32 | Read data, valid RD_LAT cycles after the request |
| de_o | output | 1 | Pixel data-enable |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| red_o | output | 8 | Red channel |
| green_o | output | 8 | Green channel |
| blue_o | output | 8 | Blue channel |

## Verification
The hardest condition to create is a register write that lands inside a visible frame and is then correctly held back until the next vertical blanking. The bench uses shrunken timing parameters and locks to each vsync falling edge. There it queues the expected reads and pixels for the coming frame, based on the settings written during the previous frame. It then waits for the second line's data-enable before writing the next settings. Every write therefore falls mid-frame, and any early take-over corrupts the address and pixel queues of the frame in flight.

// File: rtl/fb_scanout.sv
module fb_scanout #(
  parameter int H_VIS     = 640,
  parameter int H_FP      = 16,
  parameter int H_SYNC    = 96,
  parameter int H_BP      = 48,
  parameter int V_VIS     = 480,
  parameter int V_FP      = 10,
  parameter int V_SYNC    = 2,
  parameter int V_BP      = 33,
  parameter int RD_LAT    = 2,
  parameter int COL_BITS  = 10,
  parameter int LINE_BITS = 9,
  parameter int BASE_BITS = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic        mem_rd_o,
  output logic [BASE_BITS+LINE_BITS+COL_BITS-1:0] mem_addr_o,
  input  logic [31:0] mem_rdata_i,
  output logic        de_o,
  output logic        hsync_n_o,
  output logic        vsync_n_o,
  output logic [7:0]  red_o,
  output logic [7:0]  green_o,
  output logic [7:0]  blue_o
);
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam int AW    = BASE_BITS + LINE_BITS + COL_BITS;
  localparam int DLY   = RD_LAT + 1;
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [HW-1:0] H_VIS_L = HW'(H_VIS);
  localparam logic [VW-1:0] V_VIS_L = VW'(V_VIS);
  localparam logic [HW-1:0] HS_BEG = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_BEG = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_VIS + V_FP + V_SYNC);
  localparam logic [COL_BITS-1:0]  COL_MAX  = COL_BITS'(H_VIS - 1);
  localparam logic [LINE_BITS-1:0] LINE_MAX = LINE_BITS'(V_VIS - 1);

  logic [BASE_BITS-1:0] base_q, base_sh;
  logic                 en_q, rot_q, en_sh, rot_sh;
  logic [HW-1:0]        h_cnt;
  logic [VW-1:0]        v_cnt;
  logic                 vis, hs_n, vs_n, grab;
  logic [COL_BITS-1:0]  col;
  logic [LINE_BITS-1:0] line;
  logic [DLY-1:0]       de_p, hs_p, vs_p, pv_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
      rot_q  <= 1'b0;
    end else if (reg_we) begin
      if (!reg_sel) base_q <= reg_wdata[31 -: BASE_BITS];
      else begin
        en_q  <= reg_wdata[0];
        rot_q <= reg_wdata[1];
      end
    end
  end

  assign grab = (h_cnt == '0) && (v_cnt == V_VIS_L);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_sh <= '0;
      en_sh   <= 1'b0;
      rot_sh  <= 1'b0;
    end else if (grab) begin
      base_sh <= base_q;
      en_sh   <= en_q;
      rot_sh  <= rot_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (h_cnt == H_LAST) begin
      h_cnt <= '0;
      v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
    end else begin
      h_cnt <= h_cnt + 1'b1;
    end
  end

  assign vis  = (h_cnt < H_VIS_L) && (v_cnt < V_VIS_L);
  assign hs_n = !((h_cnt >= HS_BEG) && (h_cnt < HS_END));
  assign vs_n = !((v_cnt >= VS_BEG) && (v_cnt < VS_END));
  assign col  = rot_sh ? COL_MAX - COL_BITS'(h_cnt) : COL_BITS'(h_cnt);
  assign line = rot_sh ? LINE_MAX - LINE_BITS'(v_cnt) : LINE_BITS'(v_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_rd_o   <= 1'b0;
      mem_addr_o <= '0;
    end else begin
      mem_rd_o   <= vis && en_sh;
      mem_addr_o <= {base_sh, line, col};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_p <= '0;
      pv_p <= '0;
      hs_p <= '1;
      vs_p <= '1;
    end else begin
      de_p <= {de_p[DLY-2:0], vis};
      pv_p <= {pv_p[DLY-2:0], vis && en_sh};
      hs_p <= {hs_p[DLY-2:0], hs_n};
      vs_p <= {vs_p[DLY-2:0], vs_n};
    end
  end

  assign de_o      = de_p[DLY-1];
  assign hsync_n_o = hs_p[DLY-1];
  assign vsync_n_o = vs_p[DLY-1];
  assign red_o     = pv_p[DLY-1] ? mem_rdata_i[23:16] : 8'h00;
  assign green_o   = pv_p[DLY-1] ? mem_rdata_i[15:8]  : 8'h00;
  assign blue_o    = pv_p[DLY-1] ? mem_rdata_i[7:0]   : 8'h00;

  assert_visible_cols_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> (mem_addr_o[COL_BITS-1:0] <= COL_MAX));

  assert_fwd_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && $past(mem_rd_o) && !rot_sh) |->
      (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

  assert_rev_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && $past(mem_rd_o) && rot_sh) |->
      (mem_addr_o == AW'($past(mem_addr_o) - 1'b1)));

  assert_settings_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v_cnt < V_VIS_L) |=> ($stable(base_sh) && $stable(en_sh) && $stable(rot_sh)));

  assert_de_outside_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (hsync_n_o && vsync_n_o));

  assert_black_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !de_o |-> ({red_o, green_o, blue_o} == 24'h0));

  assert_no_read_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !de_p[0]) |-> 1'b0);
endmodule

// File: tb/fb_scanout_tb_top.sv
`timescale 1ns/1ps
module fb_scanout_tb_top;
  localparam int HV = 8, HF = 2, HS = 3, HB = 2;
  localparam int VV = 4, VF = 1, VS = 1, VB = 2;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        mem_rd;
  logic [29:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        de, hs_n, vs_n;
  logic [7:0]  r, g, b;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  fb_scanout #(.H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
               .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .RD_LAT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .de_o(de), .hsync_n_o(hs_n), .vsync_n_o(vs_n),
    .red_o(r), .green_o(g), .blue_o(b));

  function automatic logic [31:0] word_of(input logic [29:0] a);
    return {8'hC3, a[23:0] ^ 24'h5A3C96};
  endfunction

  logic [31:0] mp0, mp1;
  always @(posedge clk) begin
    mp0 <= word_of(mem_addr);
    mp1 <= mp0;
  end
  assign mem_rdata = mp1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic [29:0] exp_addr[$];
  logic [23:0] exp_pix[$];
  logic [31:0] cur_base = '0;
  logic [31:0] cur_ctrl = '0;
  bit armed = 0;
  bit f0_bad = 0;

  task automatic push_frame(input logic [31:0] bs, input logic [31:0] ct);
    for (int y = 0; y < VV; y++)
      for (int x = 0; x < HV; x++) begin
        int cx, ly;
        logic [29:0] a;
        cx = ct[1] ? HV - 1 - x : x;
        ly = ct[1] ? VV - 1 - y : y;
        a  = {bs[31:21], 9'(ly), 10'(cx)};
        if (ct[0]) begin
          exp_addr.push_back(a);
          exp_pix.push_back(word_of(a)[23:0]);
        end else begin
          exp_pix.push_back(24'h0);
        end
      end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (sel) cur_ctrl = d; else cur_base = d;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!armed) begin
        if (mem_rd || ({r, g, b} != 24'h0)) f0_bad = 1;
      end else begin
        if (mem_rd) begin
          if (exp_addr.size() == 0)
            chk(0, "R6", "unexpected read", 64'(mem_addr), 0);
          else begin
            logic [29:0] ea;
            ea = exp_addr.pop_front();
            chk(mem_addr == ea, "R2/R3/R4/R8", "read address", 64'(mem_addr), 64'(ea));
          end
        end
        if (de) begin
          if (exp_pix.size() == 0)
            chk(0, "R9", "extra data-enable", 64'({r, g, b}), 0);
          else begin
            logic [23:0] ep;
            ep = exp_pix.pop_front();
            chk({r, g, b} == ep, "R5/R6/R10", "pixel", 64'({r, g, b}), 64'(ep));
          end
        end
      end
    end
  end

  // sync timing monitor (R9)
  logic hs_d = 1'b1, vs_d = 1'b1;
  int hlow = 0, vper = 0;
  bit vseen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!hs_n) hlow++;
      if (hs_n && !hs_d) begin
        chk(hlow == HS, "R9", "hsync width", 64'(hlow), 64'(HS));
        hlow = 0;
      end
      vper++;
      if (!vs_n && vs_d) begin
        if (vseen) chk(vper == HT * VT, "R9", "vsync period", 64'(vper), 64'(HT * VT));
        vseen = 1; vper = 0;
      end
      hs_d = hs_n; vs_d = vs_n;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic next_frame(input logic sel0, input logic [31:0] d0,
                            input logic sel1, input logic [31:0] d1, input bit do_wr);
    @(negedge vs_n);
    if (armed) begin
      chk(exp_pix.size() == 0, "R9", "pixels left from previous frame", 64'(exp_pix.size()), 0);
      chk(exp_addr.size() == 0, "R2", "reads left from previous frame", 64'(exp_addr.size()), 0);
    end else begin
      chk(!f0_bad, "R1", "first frame idle and black", 64'(f0_bad), 0);
    end
    armed = 1;
    push_frame(cur_base, cur_ctrl);
    if (do_wr) begin
      @(posedge de); @(posedge de);
      wr(sel0, d0);
      wr(sel1, d1);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(de == 1'b0 && mem_rd == 1'b0, "R1", "reset de/read", 64'({de, mem_rd}), 0);
    chk(hs_n && vs_n, "R1", "reset syncs", 64'({hs_n, vs_n}), 64'h3);
    chk({r, g, b} == 24'h0, "R1", "reset colour", 64'({r, g, b}), 0);
    rst_n = 1'b1;
    @(posedge de); @(posedge de);
    // R8: low base bits must be ignored; forward scan R2
    wr(1'b0, 32'h1234_5678);
    wr(1'b1, 32'h0000_0001);
    // frame 1 forward; write rotated config mid-frame (R7, R4)
    next_frame(1'b0, 32'hABCF_FFFF, 1'b1, 32'h0000_0003, 1);
    // frame 2 rotated; then blank (R10, R6)
    next_frame(1'b0, 32'h0000_0000, 1'b1, 32'h0000_0000, 1);
    // frame 3 blank; restore (R10)
    next_frame(1'b0, 32'hFFE0_0000, 1'b1, 32'h0000_0001, 1);
    // frame 4 restored forward; rotate with another base
    next_frame(1'b0, 32'h0061_2345, 1'b1, 32'h0000_0003, 1);
    // frame 5 rotated
    next_frame(1'b0, 32'h0, 1'b0, 32'h0, 0);
    @(negedge vs_n);
    chk(exp_pix.size() == 0, "R9", "final pixel drain", 64'(exp_pix.size()), 0);
    chk(exp_addr.size() == 0, "R3", "final read drain", 64'(exp_addr.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule